// File: doc/BRIEF.md
# Programmable Down-Counter and Square-Wave Timer

This block is the counter/timer function of a serial controller. A 16-bit down-counter is loaded from a preload value that software writes one byte at a time. A 3-bit control field does two jobs at once. It chooses the operating mode, one-shot counting or a free-running timer. It also chooses the clock source that advances the count. Every source reaches the block as a single-cycle enable in the system clock domain. The sources are:

- an external input pin;
- the 1x transmit clock of either serial channel;
- the main crystal clock.

The pin source and the crystal source can each be taken through a divide-by-16 prescaler.

In timer mode the counter reloads itself each time it reaches terminal count. At each reload it toggles a square-wave output, so the wave period is twice the preload, measured in source ticks. In counter mode a start strobe loads the preload and the count runs down. When it reaches zero a ready flag is set, and the count keeps running and wraps until a stop strobe halts it.

Top module: `ctmr_top`

## Requirements
- R1: After reset, `ready` is 0, `wave_out` is 0 and `count_val` is 0.
- R2: A pulse on `load_hi_we` writes `wr_data` into bits 15:8 of the preload, and a pulse on `load_lo_we` writes it into bits 7:0. The other byte is kept. A preload value of 0 or 1 is used as 2.
- R3: One cycle after `start_stb`, `count_val` equals the effective preload and `ready` is 0. In timer mode `wave_out` is also 1 at that point. When `start_stb` and `stop_stb` arrive together, the start wins and the stop has no effect.
- R4: In counter mode (`mode_sel[2]`=0), each selected source tick while running lowers `count_val` by one. The tick that brings it from 1 to 0 sets `ready`. The count then wraps from 0 to 16'hFFFF and keeps going.
- R5: In counter mode, `stop_stb` clears `ready` and halts the count, so later source ticks leave `count_val` unchanged.
- R6: In timer mode (`mode_sel[2]`=1), a source tick at count 1 reloads the effective preload, toggles `wave_out` and sets `ready`. Other ticks decrement the count. `stop_stb` clears `ready` but does not halt the timer.
- R7: The `mode_sel` codes are:
  - 000: counter mode, clocked by `pin_tick`.
  - 001: counter mode, clocked by `txa_tick`.
  - 010: counter mode, clocked by `txb_tick`.
  - 011: counter mode, clocked by `xtal_tick`/16.
  - 100: timer mode, clocked by `pin_tick`.
  - 101: timer mode, clocked by `pin_tick`/16.
  - 110: timer mode, clocked by `xtal_tick`.
  - 111: timer mode, clocked by `xtal_tick`/16.

  Ticks on an unselected source leave the count unchanged.
- R8: In a divided mode, the 16th base tick produces one counting tick, and so does every 16th base tick after it. The prescaler is cleared in the cycle after `mode_sel` changes, and that cycle produces no tick.
- R9: Before the first start, the count does not move on source ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Mode and clock source code |
| wr_data | input | 8 | Preload byte data |
| load_hi_we | input | 1 | Write strobe for the preload upper byte |
| load_lo_we | input | 1 | Write strobe for the preload lower byte |
| start_stb | input | 1 | Load the preload and run |
| stop_stb | input | 1 | Clear ready; in counter mode also halt |
| pin_tick | input | 1 | External pin source enable |
| txa_tick | input | 1 | Channel A transmit 1x clock enable |
| txb_tick | input | 1 | Channel B transmit 1x clock enable |
| xtal_tick | input | 1 | Main clock enable |
| ready | output | 1 | Terminal-count flag |
| wave_out | output | 1 | Square-wave output |
| count_val | output | 16 | Current counter value |

## Verification
The assertions check the following on every cycle:
- a start loads the effective preload;
- in counter mode each internal tick takes exactly one off the count;
- counting from 1 to 0 raises ready;
- a stop clears ready;
- the idle count stays put;
- the wave changes only on a start or on a timer reload.

Some behaviours can only be shown by the bench scenarios, because they depend on long stimulus histories:
- the mapping of each code to its source;
- the divide-by-16 spacing, and the restart of that spacing after a mode change;
- the byte-wise preload writes and the clamp;
- the wrap past zero;
- the measured half period of the wave.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

  typedef enum logic [1:0] {
    SRC_PIN  = 2'd0,
    SRC_TXA  = 2'd1,
    SRC_TXB  = 2'd2,
    SRC_XTAL = 2'd3
  } src_kind_e;

  typedef struct packed {
    src_kind_e src;
    logic      div;
    logic      timer;
  } mode_dec_t;

  // Mode code to source, prescale and mode decode
  function automatic mode_dec_t decode_mode(input logic [2:0] code);
    mode_dec_t d;
    d.timer = code[2];
    d.div   = 1'b0;
    d.src   = SRC_PIN;
    case (code)
      3'b000: d.src = SRC_PIN;
      3'b001: d.src = SRC_TXA;
      3'b010: d.src = SRC_TXB;
      3'b011: begin d.src = SRC_XTAL; d.div = 1'b1; end
      3'b100: d.src = SRC_PIN;
      3'b101: begin d.src = SRC_PIN;  d.div = 1'b1; end
      3'b110: d.src = SRC_XTAL;
      default: begin d.src = SRC_XTAL; d.div = 1'b1; end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/ctmr_preload.sv
module ctmr_preload #(
  parameter int CNT_W    = 16,
  parameter int BYTE_W   = 8,
  parameter int MIN_LOAD = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [BYTE_W-1:0]         wr_data,
  input  logic [CNT_W/BYTE_W-1:0]   lane_we,
  output logic [CNT_W-1:0]          eff_load
);

  localparam int NLANE = CNT_W / BYTE_W;
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_LOAD);

  logic [CNT_W-1:0] raw_q;

  genvar g;
  generate
    for (g = 0; g < NLANE; g++) begin : g_lane
      logic [BYTE_W-1:0] lane_n;
      logic [BYTE_W-1:0] lane_q;

      always_comb begin
        lane_n = lane_q;
        if (lane_we[g]) lane_n = wr_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lane_q <= '0;
        else        lane_q <= lane_n;
      end

      assign raw_q[g*BYTE_W +: BYTE_W] = lane_q;
    end
  endgenerate

  always_comb begin
    eff_load = raw_q;
    if (raw_q < MIN_V) eff_load = MIN_V;
  end

endmodule

// File: rtl/ctmr_src_sel.sv
module ctmr_src_sel
  import ctmr_pkg::*;
#(
  parameter int PRESC_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_sel,
  input  logic       pin_tick,
  input  logic       txa_tick,
  input  logic       txb_tick,
  input  logic       xtal_tick,
  output logic       src_tick,
  output logic       is_timer
);

  mode_dec_t dec;
  logic      base_tick;
  logic [2:0] mode_q;
  logic       mode_chg;

  assign dec      = decode_mode(mode_sel);
  assign is_timer = dec.timer;
  assign mode_chg = (mode_sel != mode_q);

  always_comb begin
    case (dec.src)
      SRC_PIN:  base_tick = pin_tick;
      SRC_TXA:  base_tick = txa_tick;
      SRC_TXB:  base_tick = txb_tick;
      default:  base_tick = xtal_tick;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_sel;
  end

  generate
    if (PRESC_W > 0) begin : g_presc
      logic [PRESC_W-1:0] presc_q;
      logic [PRESC_W-1:0] presc_n;

      always_comb begin
        presc_n = presc_q;
        if (mode_chg)                 presc_n = '0;
        else if (base_tick && dec.div) presc_n = presc_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) presc_q <= '0;
        else        presc_q <= presc_n;
      end

      assign src_tick = !mode_chg && base_tick && (!dec.div || (presc_q == '1));
    end else begin : g_nopresc
      assign src_tick = !mode_chg && base_tick;
    end
  endgenerate

endmodule

// File: rtl/ctmr_core.sv
module ctmr_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_timer,
  input  logic             src_tick,
  input  logic             start_stb,
  input  logic             stop_stb,
  input  logic [CNT_W-1:0] eff_load,
  output logic [CNT_W-1:0] count_q,
  output logic             run_q,
  output logic             ready_q,
  output logic             wave_q
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_n;
  logic             run_n;
  logic             ready_n;
  logic             wave_n;

  always_comb begin
    count_n = count_q;
    run_n   = run_q;
    ready_n = ready_q;
    wave_n  = wave_q;
    if (start_stb) begin
      count_n = eff_load;
      run_n   = 1'b1;
      ready_n = 1'b0;
      if (is_timer) wave_n = 1'b1;
    end else if (stop_stb && !is_timer) begin
      run_n   = 1'b0;
      ready_n = 1'b0;
    end else begin
      if (run_q && src_tick) begin
        if (is_timer) begin
          if (count_q <= ONE) begin
            count_n = eff_load;
            wave_n  = !wave_q;
            ready_n = 1'b1;
          end else begin
            count_n = count_q - ONE;
          end
        end else begin
          count_n = count_q - ONE;
          if (count_q == ONE) ready_n = 1'b1;
        end
      end
      if (stop_stb) ready_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      run_q   <= 1'b0;
      ready_q <= 1'b0;
      wave_q  <= 1'b0;
    end else begin
      count_q <= count_n;
      run_q   <= run_n;
      ready_q <= ready_n;
      wave_q  <= wave_n;
    end
  end

endmodule

// File: rtl/ctmr_top.sv
module ctmr_top #(
  parameter int CNT_W    = 16,
  parameter int BYTE_W   = 8,
  parameter int PRESC_W  = 4,
  parameter int MIN_LOAD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_sel,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              load_hi_we,
  input  logic              load_lo_we,
  input  logic              start_stb,
  input  logic              stop_stb,
  input  logic              pin_tick,
  input  logic              txa_tick,
  input  logic              txb_tick,
  input  logic              xtal_tick,
  output logic              ready,
  output logic              wave_out,
  output logic [CNT_W-1:0]  count_val
);

  logic [CNT_W-1:0] eff_load;
  logic             src_tick;
  logic             is_timer;
  logic             run_q;

  ctmr_preload #(
    .CNT_W(CNT_W), .BYTE_W(BYTE_W), .MIN_LOAD(MIN_LOAD)
  ) u_preload (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_data  (wr_data),
    .lane_we  ({load_hi_we, load_lo_we}),
    .eff_load (eff_load)
  );

  ctmr_src_sel #(.PRESC_W(PRESC_W)) u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .pin_tick  (pin_tick),
    .txa_tick  (txa_tick),
    .txb_tick  (txb_tick),
    .xtal_tick (xtal_tick),
    .src_tick  (src_tick),
    .is_timer  (is_timer)
  );

  ctmr_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .is_timer  (is_timer),
    .src_tick  (src_tick),
    .start_stb (start_stb),
    .stop_stb  (stop_stb),
    .eff_load  (eff_load),
    .count_q   (count_val),
    .run_q     (run_q),
    .ready_q   (ready),
    .wave_q    (wave_out)
  );

endmodule

// File: rtl/ctmr_chk.sv
module ctmr_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode_sel,
  input logic             start_stb,
  input logic             stop_stb,
  input logic             src_tick,
  input logic             run_q,
  input logic [CNT_W-1:0] eff_load,
  input logic             ready,
  input logic             wave_out,
  input logic [CNT_W-1:0] count_val
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // R3
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_stb |=> (count_val == $past(eff_load)) && !ready);

  // R4
  ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_stb && !stop_stb && run_q && src_tick && !mode_sel[2])
      |=> count_val == ($past(count_val) - ONE));

  // R4
  ctr_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_stb && !stop_stb && run_q && src_tick && !mode_sel[2] && count_val == ONE)
      |=> ready);

  // R5
  stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_stb && !start_stb) |=> !ready);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !start_stb) |=> $stable(count_val));

  // R6
  wave_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wave_out != $past(wave_out))
      |-> $past(start_stb || (run_q && src_tick && mode_sel[2] && count_val <= ONE)));

endmodule

bind ctmr_top ctmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_sel  (mode_sel),
  .start_stb (start_stb),
  .stop_stb  (stop_stb),
  .src_tick  (src_tick),
  .run_q     (run_q),
  .eff_load  (eff_load),
  .ready     (ready),
  .wave_out  (wave_out),
  .count_val (count_val)
);

// File: tb/tb_ctmr_top.sv
`timescale 1ns/1ps
module tb_ctmr_top;

  logic        clk;
  logic        rst_n;
  logic [2:0]  mode_sel;
  logic [7:0]  wr_data;
  logic        load_hi_we, load_lo_we, start_stb, stop_stb;
  logic        pin_tick, txa_tick, txb_tick, xtal_tick;
  logic        ready, wave_out;
  logic [15:0] count_val;

  int checks = 0;
  int errors = 0;

  ctmr_top dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .wr_data(wr_data),
    .load_hi_we(load_hi_we), .load_lo_we(load_lo_we),
    .start_stb(start_stb), .stop_stb(stop_stb),
    .pin_tick(pin_tick), .txa_tick(txa_tick), .txb_tick(txb_tick), .xtal_tick(xtal_tick),
    .ready(ready), .wave_out(wave_out), .count_val(count_val)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_mode(input logic [2:0] m);
    mode_sel = m;
    @(negedge clk);
  endtask

  task automatic write_pre(input logic [7:0] hi, input logic [7:0] lo);
    wr_data = hi; load_hi_we = 1'b1;
    @(negedge clk);
    load_hi_we = 1'b0;
    wr_data = lo; load_lo_we = 1'b1;
    @(negedge clk);
    load_lo_we = 1'b0;
  endtask

  task automatic write_hi(input logic [7:0] hi);
    wr_data = hi; load_hi_we = 1'b1;
    @(negedge clk);
    load_hi_we = 1'b0;
  endtask

  task automatic do_start;
    start_stb = 1'b1;
    @(negedge clk);
    start_stb = 1'b0;
  endtask

  task automatic do_stop;
    stop_stb = 1'b1;
    @(negedge clk);
    stop_stb = 1'b0;
  endtask

  // which: 0 pin, 1 txa, 2 txb, 3 xtal
  task automatic tick(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      pin_tick  = (which == 0);
      txa_tick  = (which == 1);
      txb_tick  = (which == 2);
      xtal_tick = (which == 3);
      @(negedge clk);
    end
    pin_tick = 1'b0; txa_tick = 1'b0; txb_tick = 1'b0; xtal_tick = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 ready", {15'd0, ready}, 16'd0);
    check("R1 wave", {15'd0, wave_out}, 16'd0);
    check("R1 count", count_val, 16'd0);
    set_mode(3'b000);
    tick(0, 3);
    check("R9 no count before start", count_val, 16'd0);
  endtask

  task automatic t_counter_basic;
    set_mode(3'b001);
    write_pre(8'h00, 8'h05);
    do_start;
    check("R3 load", count_val, 16'd5);
    check("R3 ready clear", {15'd0, ready}, 16'd0);
    tick(1, 4);
    check("R4 count to 1", count_val, 16'd1);
    check("R4 no early ready", {15'd0, ready}, 16'd0);
    tick(1, 1);
    check("R4 terminal", count_val, 16'd0);
    check("R4 ready set", {15'd0, ready}, 16'd1);
    tick(1, 1);
    check("R4 wrap", count_val, 16'hFFFF);
    tick(2, 3);
    check("R7 unselected txb", count_val, 16'hFFFF);
    do_stop;
    check("R5 stop clears ready", {15'd0, ready}, 16'd0);
    tick(1, 2);
    check("R5 halted", count_val, 16'hFFFF);
  endtask

  task automatic t_clamp;
    write_pre(8'h00, 8'h01);
    do_start;
    check("R2 clamp 1", count_val, 16'd2);
    write_pre(8'h00, 8'h00);
    do_start;
    check("R2 clamp 0", count_val, 16'd2);
    write_pre(8'h12, 8'h34);
    do_start;
    check("R2 byte order", count_val, 16'h1234);
    write_hi(8'hAB);
    do_start;
    check("R2 low byte kept", count_val, 16'hAB34);
  endtask

  task automatic t_priority;
    set_mode(3'b001);
    do_start;
    tick(1, 1);
    check("R3 running", count_val, 16'hAB33);
    start_stb = 1'b1; stop_stb = 1'b1;
    @(negedge clk);
    start_stb = 1'b0; stop_stb = 1'b0;
    check("R3 start beats stop", count_val, 16'hAB34);
    tick(1, 1);
    check("R3 still running", count_val, 16'hAB33);
  endtask

  task automatic t_src_codes;
    set_mode(3'b000);
    write_pre(8'h00, 8'd100);
    do_start;
    tick(0, 3);
    check("R7 code000 pin", count_val, 16'd97);
    tick(3, 3);
    tick(1, 2);
    check("R7 code000 ignores others", count_val, 16'd97);
    set_mode(3'b010);
    tick(2, 2);
    check("R7 code010 txb", count_val, 16'd95);
    tick(1, 2);
    check("R7 code010 ignores txa", count_val, 16'd95);
    set_mode(3'b110);
    tick(3, 1);
    check("R7 code110 xtal", count_val, 16'd94);
    set_mode(3'b100);
    tick(0, 1);
    check("R7 code100 pin", count_val, 16'd93);
  endtask

  task automatic t_div16;
    set_mode(3'b011);
    write_pre(8'h00, 8'd10);
    do_start;
    tick(3, 15);
    check("R8 15 base ticks", count_val, 16'd10);
    tick(3, 1);
    check("R8 16th base tick", count_val, 16'd9);
    tick(3, 8);
    set_mode(3'b101);
    set_mode(3'b011);
    tick(3, 15);
    check("R8 prescaler cleared on mode change", count_val, 16'd9);
    tick(3, 1);
    check("R8 tick after clear", count_val, 16'd8);
  endtask

  task automatic t_timer;
    set_mode(3'b110);
    write_pre(8'h00, 8'h03);
    do_start;
    check("R3 timer load", count_val, 16'd3);
    check("R3 timer wave high", {15'd0, wave_out}, 16'd1);
    tick(3, 2);
    check("R6 count down", count_val, 16'd1);
    check("R6 wave held", {15'd0, wave_out}, 16'd1);
    tick(3, 1);
    check("R6 reload", count_val, 16'd3);
    check("R6 wave toggled", {15'd0, wave_out}, 16'd0);
    check("R6 ready set", {15'd0, ready}, 16'd1);
    do_stop;
    check("R6 stop clears ready", {15'd0, ready}, 16'd0);
    tick(3, 2);
    check("R6 keeps running", count_val, 16'd1);
    check("R6 low half", {15'd0, wave_out}, 16'd0);
    tick(3, 1);
    check("R6 half period", {15'd0, wave_out}, 16'd1);
  endtask

  task automatic finish_run;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL all watchdog actual=hung expected=done");
    finish_run;
  end

  initial begin
    rst_n = 1'b0;
    mode_sel = 3'b000; wr_data = '0;
    load_hi_we = 0; load_lo_we = 0; start_stb = 0; stop_stb = 0;
    pin_tick = 0; txa_tick = 0; txb_tick = 0; xtal_tick = 0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset;
    t_counter_basic;
    t_clamp;
    t_priority;
    t_src_codes;
    t_div16;
    t_timer;
    idle(2);
    finish_run;
  end

endmodule